// File: doc/BRIEF.md
# Sequential 8-bit Multiply/Divide Unit

This unit performs the two long arithmetic operations of a small accumulator machine: an unsigned multiply of the accumulator by the index register, and an unsigned division of a 16-bit dividend by the index register. The dividend is formed from the high-index register (upper byte) and the accumulator (lower byte). The surrounding core samples its accumulator, index and high-index registers and raises `start` for one cycle together with an operation select. It then waits for `done`. While `done` is high, the unit offers new register values and flag values. Each of these comes with its own write-enable, so the core only has to copy what is enabled.

The work is iterative. A single pair of shift registers is shared by the shift-and-add multiply and the restoring divide. Both retire one bit per clock, so every operation takes the same fixed number of cycles. For a divide whose quotient would not fit in one byte, including a divide by zero, the carry flag is set and none of the registers is written.

Top module: `muldiv_unit`

## Requirements
- R1: Multiply (`op_div`=0): with `done` high, `idx_out` holds bits 15..8 and `acc_out` bits 7..0 of `acc_in*idx_in`; `acc_we`=1, `idx_we`=1, `hi_we`=0.
- R2: Multiply clears carry and half-carry (`cf_we`=1, `cf`=0, `hf_we`=1, `hf`=0) and leaves zero untouched (`zf_we`=0).
- R3: Divide (`op_div`=1) with quotient `{hi_in,acc_in}/idx_in` at most 0xFF: `acc_out` is the quotient, `hi_out` the remainder, `acc_we`=1, `hi_we`=1, `idx_we`=0.
- R4: A successful divide writes zero (`zf_we`=1), with `zf`=1 exactly when the quotient is 0.
- R5: A divide whose quotient exceeds 0xFF sets carry (`cf_we`=1, `cf`=1), writes no register (all three write-enables 0), does not write zero or half-carry, and presents the unchanged operands on `acc_out`, `idx_out`, `hi_out`.
- R6: A divide by zero behaves exactly as in R5.
- R7: A successful divide clears carry (`cf_we`=1, `cf`=0) and does not write half-carry.
- R8: `done` rises after the 8th rising edge that follows the edge accepting `start`, and it stays high for exactly one cycle.
- R9: A `start` that arrives while an operation is in progress is ignored: the running operation completes with its own operands and its original timing.
- R10: After reset, `done` and every data, flag and write-enable output is 0; all of them stay 0 whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| acc_in | input | 8 | Accumulator value |
| idx_in | input | 8 | Index value (multiplicand / divisor) |
| hi_in | input | 8 | High-index value (dividend upper byte) |
| acc_out | output | 8 | New accumulator value |
| idx_out | output | 8 | New index value |
| hi_out | output | 8 | New high-index value |
| acc_we | output | 1 | Write accumulator |
| idx_we | output | 1 | Write index |
| hi_we | output | 1 | Write high-index |
| done | output | 1 | One-cycle completion pulse |
| cf | output | 1 | Carry flag value |
| cf_we | output | 1 | Carry flag write |
| zf | output | 1 | Zero flag value |
| zf_we | output | 1 | Zero flag write |
| hf | output | 1 | Half-carry flag value |
| hf_we | output | 1 | Half-carry flag write |

## Verification
The assertions check several things on every cycle. They check the single-cycle shape of `done`. They check that a busy unit neither restarts nor re-captures its operands. They check that the running remainder of a valid divide stays below the divisor. They also check the write-enable and flag patterns of multiply, successful divide and failed divide. Whether the numbers are right can only be shown by the bench's sweeps. These compare every product, quotient and remainder with arithmetic computed in the bench, over a grid of multiplies and divides. They also cover the boundaries: the largest valid quotient, a high byte equal to the divisor, and a divisor of zero. A separate scenario injects a second `start` into a running operation and checks the latency.

// File: rtl/md_pkg.sv
// Package: shared types of the multiply/divide unit.
// Assumes: the operation select is a single bit driven by the decoder.
package md_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/md_ctrl.sv
// Module: md_ctrl
// Sequencer for the iterative datapath. It accepts start only when idle,
// then holds busy for STEPS cycles and pulses done once after the last step.
// Assumes: start may arrive at any time; starts during busy are dropped.
module md_ctrl #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;
    logic          last;

    assign load = start && !busy_q;
    assign last = busy_q && (cnt_q == LAST);
    assign busy = busy_q;
    assign done = done_q;

    // Step counter, busy flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
endmodule

// File: rtl/md_mul_step.sv
// Module: md_mul_step
// One shift-and-add multiply step. {hi,lo} is the partial product; lo's
// low bit selects whether the multiplicand is added into hi before the
// 2W+1-bit value shifts right by one.
// Assumes: hi starts at zero and lo holds the multiplier.
module md_mul_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] hi_n,
    output logic [W-1:0] lo_n
);
    logic [W:0] sum;

    // Conditional add followed by the right shift.
    always_comb begin
        sum  = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
        hi_n = sum[W:1];
        lo_n = {sum[0], lo[W-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
// Module: md_div_step
// One restoring-division step. The remainder shifts left and takes in the
// next dividend bit from the top of quo; the divisor is subtracted when it
// fits, and the resulting quotient bit enters quo at the bottom.
// Assumes: rem < dvs on entry (caller screens overflow beforehand).
module md_div_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;

    // Trial subtraction and restore decision.
    always_comb begin
        trial = {rem, quo[W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
        rem_n = fits ? diff[W-1:0] : trial[W-1:0];
        quo_n = {quo[W-2:0], fits};
    end
endmodule

// File: rtl/muldiv_unit.sv
// Module: muldiv_unit
// Iterative unsigned multiply (acc*idx -> idx:acc) and divide
// ({hi,acc}/idx -> acc quotient, hi remainder). It shares a single pair of
// shift registers between both operations, completes in W steps and
// presents results with per-register and per-flag write-enables while
// done is high.
// Assumes: the core holds no expectation on outputs while done is low.
module muldiv_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] idx_in,
    input  logic [W-1:0] hi_in,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] idx_out,
    output logic [W-1:0] hi_out,
    output logic         acc_we,
    output logic         idx_we,
    output logic         hi_we,
    output logic         done,
    output logic         cf,
    output logic         cf_we,
    output logic         zf,
    output logic         zf_we,
    output logic         hf,
    output logic         hf_we
);
    import md_pkg::*;

    logic         load;
    logic         busy;
    md_op_e       op_q;
    logic         fail_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;
    logic [W-1:0] x_q;
    logic [W-1:0] a_cap;
    logic [W-1:0] h_cap;
    logic [W-1:0] mul_hi_n;
    logic [W-1:0] mul_lo_n;
    logic [W-1:0] div_rem_n;
    logic [W-1:0] div_quo_n;

    md_ctrl #(.STEPS(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .done  (done)
    );

    md_mul_step #(.W(W)) u_mul (
        .hi    (hi_q),
        .lo    (lo_q),
        .mcand (x_q),
        .hi_n  (mul_hi_n),
        .lo_n  (mul_lo_n)
    );

    md_div_step #(.W(W)) u_div (
        .rem   (hi_q),
        .quo   (lo_q),
        .dvs   (x_q),
        .rem_n (div_rem_n),
        .quo_n (div_quo_n)
    );

    // Operand capture on accept, then one datapath step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MUL;
            fail_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            x_q    <= '0;
            a_cap  <= '0;
            h_cap  <= '0;
        end else if (load) begin
            op_q   <= md_op_e'(op_div);
            fail_q <= op_div && (hi_in >= idx_in);
            hi_q   <= op_div ? hi_in : '0;
            lo_q   <= acc_in;
            x_q    <= idx_in;
            a_cap  <= acc_in;
            h_cap  <= hi_in;
        end else if (busy) begin
            if (op_q == OP_DIV) begin
                hi_q <= div_rem_n;
                lo_q <= div_quo_n;
            end else begin
                hi_q <= mul_hi_n;
                lo_q <= mul_lo_n;
            end
        end
    end

    // Result, write-enable and flag selection while done is high.
    always_comb begin
        acc_out = '0;
        idx_out = '0;
        hi_out  = '0;
        acc_we  = 1'b0;
        idx_we  = 1'b0;
        hi_we   = 1'b0;
        cf      = 1'b0;
        cf_we   = 1'b0;
        zf      = 1'b0;
        zf_we   = 1'b0;
        hf      = 1'b0;
        hf_we   = 1'b0;
        if (done) begin
            cf_we = 1'b1;
            if (op_q == OP_MUL) begin
                acc_out = lo_q;
                idx_out = hi_q;
                hi_out  = h_cap;
                acc_we  = 1'b1;
                idx_we  = 1'b1;
                hf_we   = 1'b1;
            end else if (fail_q) begin
                acc_out = a_cap;
                idx_out = x_q;
                hi_out  = h_cap;
                cf      = 1'b1;
            end else begin
                acc_out = lo_q;
                idx_out = x_q;
                hi_out  = hi_q;
                acc_we  = 1'b1;
                hi_we   = 1'b1;
                zf_we   = 1'b1;
                zf      = (lo_q == '0);
            end
        end
    end

    // R2
    mul_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MUL) |-> (cf_we && !cf && hf_we && !hf && !zf_we));

    // R5 R6
    div_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_DIV && cf) |-> (!acc_we && !idx_we && !hi_we && !zf_we));

    // R7
    div_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_DIV && !cf) |-> (cf_we && acc_we && hi_we && !idx_we && !hf_we));

    // R3
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == OP_DIV && !fail_q) |-> (hi_q < x_q));

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(x_q) && $stable(a_cap) && $stable(op_q)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(acc_we || idx_we || hi_we || cf_we || zf_we || hf_we));
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_div = 1'b0;
    logic [W-1:0] acc_in = '0, idx_in = '0, hi_in = '0;
    logic [W-1:0] acc_out, idx_out, hi_out;
    logic         acc_we, idx_we, hi_we, done, cf, cf_we, zf, zf_we, hf, hf_we;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    muldiv_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .acc_in(acc_in), .idx_in(idx_in), .hi_in(hi_in),
        .acc_out(acc_out), .idx_out(idx_out), .hi_out(hi_out),
        .acc_we(acc_we), .idx_we(idx_we), .hi_we(hi_we), .done(done),
        .cf(cf), .cf_we(cf_we), .zf(zf), .zf_we(zf_we), .hf(hf), .hf_we(hf_we)
    );

    function automatic logic [32:0] actual_vec();
        return {acc_out, idx_out, hi_out, acc_we, idx_we, hi_we,
                cf_we, cf, zf_we, zf, hf_we, hf};
    endfunction

    // Expected outputs while done is high, from the requirements.
    function automatic logic [32:0] expect_vec(input logic dv, input int a, input int x, input int h);
        int p, dd, q, r;
        if (!dv) begin
            p = a * x;
            return {8'(p), 8'(p >> 8), 8'(h), 3'b110, 2'b10, 2'b00, 2'b10};
        end
        dd = (h << 8) | a;
        if (x == 0 || (dd / x) > 255)
            return {8'(a), 8'(x), 8'(h), 3'b000, 2'b11, 2'b00, 2'b00};
        q = dd / x;
        r = dd % x;
        return {8'(q), 8'(x), 8'(r), 3'b101, 2'b10, 1'b1, (q == 0), 2'b00};
    endfunction

    function automatic string tag_of(input logic dv, input int a, input int x, input int h);
        int dd;
        dd = (h << 8) | a;
        if (!dv) return "R1 R2";
        if (x == 0) return "R6";
        if ((dd / x) > 255) return "R5";
        return "R3 R4 R7";
    endfunction

    // Run one operation; optionally inject a second start mid-run (R9).
    task automatic run_op(input logic dv, input int a, input int x, input int h, input bit inject);
        int lat;
        logic [32:0] got, exp;
        @(negedge clk);
        op_div = dv; acc_in = 8'(a); idx_in = 8'(x); hi_in = 8'(h); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 3) begin
                start = 1'b1; op_div = ~dv; acc_in = ~acc_in; idx_in = ~idx_in; hi_in = 8'h00;
            end else begin
                start = 1'b0;
            end
        end
        got = actual_vec();
        exp = expect_vec(dv, a, x, h);
        n_vec++;
        if (got !== exp || lat != W + 1) begin
            n_bad++;
            $display("FAIL %s%s op=%0d a=%02h x=%02h h=%02h got=%09h lat=%0d exp=%09h lat=%0d",
                     tag_of(dv, a, x, h), inject ? " R9" : "", dv, a, x, h, got, lat, exp, W + 1);
        end
    endtask

    // R8: done must be low in the cycle after the pulse.
    task automatic check_pulse_end();
        @(negedge clk);
        n_vec++;
        if (done !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 done after pulse got=%b exp=0", done);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        n_vec++;
        if ({done, actual_vec()} !== 34'd0) begin
            n_bad++;
            $display("FAIL R10 reset got=%09h exp=0", {done, actual_vec()});
        end
        // R8 pulse shape
        run_op(1'b0, 200, 3, 7, 1'b0);
        check_pulse_end();
        // R10: outputs quiet while done is low
        n_vec++;
        if (actual_vec() !== 33'd0) begin
            n_bad++;
            $display("FAIL R10 idle got=%09h exp=0", actual_vec());
        end
        // R9: injected start while busy, both operation kinds
        run_op(1'b0, 8'h12, 8'h34, 8'h56, 1'b1);
        run_op(1'b1, 8'h40, 8'h09, 8'h05, 1'b1);
        run_op(1'b1, 8'h00, 8'h00, 8'h01, 1'b1);
        // R1 R2 multiply sweep
        for (int a = 0; a < 256; a += 17)
            for (int x = 0; x < 256; x++)
                run_op(1'b0, a, x, (a ^ x) & 255, 1'b0);
        // R3 R4 R5 R6 R7 divide grid
        for (int h = 0; h < 256; h += 17)
            for (int x = 0; x < 256; x += 3)
                run_op(1'b1, (h * 7 + x) & 255, x, h, 1'b0);
        // Boundaries: largest valid quotient vs first overflow, zero quotient
        for (int x = 1; x < 256; x++) begin
            run_op(1'b1, 255, x, x - 1, 1'b0);
            run_op(1'b1, 0, x, x, 1'b0);
        end
        run_op(1'b1, 0, 0, 0, 1'b0);
        run_op(1'b1, 3, 200, 0, 1'b0);
        run_op(1'b1, 255, 1, 0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule